// File: doc/BRIEF.md
# Completion-Sensing Ripple Adder

An unsigned integer adder whose finishing time follows the data. A caller starts an
addition by flipping a request line and waits for the acknowledge line to flip in
return; the operands travel alongside the request and are captured on the clock edge
that sees the flip. Inside, every bit position keeps a three-valued carry state:
unknown, known zero or known one. A bit whose two operand bits agree settles at once,
as a kill or a generate. A bit whose operand bits differ takes on its lower neighbour's
state one cycle after that neighbour settles. The acknowledge flips once every position
has settled.

Because carries move one position per cycle, the wait is short for typical data. It
grows only with the longest run of propagating bits actually present, not with the
width. A subtract input turns the operation into A minus B by inverting the second
operand and forcing the carry-in to one.

Top module: `ripple_done_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, ack_tgl, sum_out and carry_out are all 0.
- R2: When idle, a change of level on req_tgl in either direction is sampled on the next rising clock edge. That edge starts an operation using the operand values present at it.
- R3: With sub_mode = 0, the result {carry_out, sum_out} equals op_a + op_b + carry_in as a W+1 bit unsigned sum.
- R4: With sub_mode = 1, the result equals op_a + ~op_b + 1 and carry_in is ignored. carry_out is 1 exactly when op_a >= op_b (unsigned).
- R5: Let B' be the effective second operand (op_b, or ~op_b when subtracting). Let L be the length of the longest run of adjacent bit positions with op_a[i] != B'[i] (0 when there is none). ack_tgl flips on the (L+2)-th rising edge after the sampling edge and not before.
- R6: ack_tgl flips exactly once per operation. sum_out and carry_out change only on the edge where ack_tgl flips.
- R7: Changes to op_a, op_b, carry_in or sub_mode after the sampling edge have no effect on the running operation's result or timing.
- R8: A req_tgl change that arrives while an operation runs is held. It starts the next operation on the first rising edge after the acknowledge edge, using the operands present at that edge.
- R9: When every bit propagates (L = W), ack_tgl flips on the (W+2)-th edge after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_tgl | input | 1 | Request; every change of level asks for one operation |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 when adding |
| sub_mode | input | 1 | 1 selects op_a minus op_b |
| sum_out | output | W | Registered result |
| carry_out | output | 1 | Registered carry out of the top bit |
| ack_tgl | output | 1 | Acknowledge; flips once when the result is valid |

## Verification
Two functions can fall in the same cycle: the completion of one operation and the arrival of the next request. The bench provokes this by flipping req_tgl and changing every operand one cycle after an operation has started. The first result and its cycle count must be unaffected by the new operands. The second operation must begin on the edge right after the first acknowledge, and its own latency and sum must match a bench model that counts propagate runs.

// File: rtl/rda_pkg.sv
package rda_pkg;
  // Carry state of one position
  localparam logic [1:0] CS_UNK  = 2'b00;
  localparam logic [1:0] CS_ZERO = 2'b01;
  localparam logic [1:0] CS_ONE  = 2'b10;
endpackage

// File: rtl/rda_operand_stage.sv
module rda_operand_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  input  logic         sub_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         c_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= sub_in ? ~b_in : b_in;
      c_q <= sub_in | c_in;
    end
  end
endmodule

// File: rtl/rda_carry_cell.sv
module rda_carry_cell
  import rda_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       x_bit,
  input  logic       y_bit,
  input  logic [1:0] low_st,
  output logic [1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st_q <= CS_UNK;
    end else if (st_q == CS_UNK) begin
      if (x_bit == y_bit) st_q <= x_bit ? CS_ONE : CS_ZERO;
      else                st_q <= low_st;
    end
  end
endmodule

// File: rtl/rda_resolve.sv
module rda_resolve
  import rda_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:0][1:0] st_vec,
  input  logic [W-1:0]    a_q,
  input  logic [W-1:0]    b_q,
  output logic            all_known,
  output logic [W-1:0]    sum_c,
  output logic            cout_c
);
  logic [W:0] known;
  for (genvar i = 0; i <= W; i++) begin : g_known
    assign known[i] = (st_vec[i] != CS_UNK);
  end
  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum_c[i] = a_q[i] ^ b_q[i] ^ (st_vec[i] == CS_ONE);
  end
  assign all_known = &known;
  assign cout_c    = (st_vec[W] == CS_ONE);
endmodule

// File: rtl/ripple_done_adder.sv
module ripple_done_adder
  import rda_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_tgl,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         sub_mode,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         ack_tgl
);
  localparam int NPOS = W + 1;

  logic            req_seen;
  logic            busy;
  logic            start;
  logic [W-1:0]    a_q, b_q;
  logic            c_q;
  logic [W:0][1:0] st_vec;
  logic            all_known;
  logic [W-1:0]    sum_c;
  logic            cout_c;

  assign start = !busy && (req_tgl != req_seen);

  rda_operand_stage #(.W(W)) u_ops (
    .clk(clk), .rst(rst), .load(start),
    .a_in(op_a), .b_in(op_b), .c_in(carry_in), .sub_in(sub_mode),
    .a_q(a_q), .b_q(b_q), .c_q(c_q)
  );

  // Position 0 models the incoming carry; position i+1 is the carry out of bit i.
  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    if (p == 0) begin : g_cin
      rda_carry_cell u_cell (
        .clk(clk), .rst(rst), .clear(start),
        .x_bit(c_q), .y_bit(c_q), .low_st(CS_UNK), .st_q(st_vec[0])
      );
    end else begin : g_bit
      rda_carry_cell u_cell (
        .clk(clk), .rst(rst), .clear(start),
        .x_bit(a_q[p-1]), .y_bit(b_q[p-1]), .low_st(st_vec[p-1]),
        .st_q(st_vec[p])
      );
    end
  end

  rda_resolve #(.W(W)) u_resolve (
    .st_vec(st_vec), .a_q(a_q), .b_q(b_q),
    .all_known(all_known), .sum_c(sum_c), .cout_c(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen  <= 1'b0;
      busy      <= 1'b0;
      ack_tgl   <= 1'b0;
      sum_out   <= '0;
      carry_out <= 1'b0;
    end else if (start) begin
      req_seen <= req_tgl;
      busy     <= 1'b1;
    end else if (busy && all_known) begin
      busy      <= 1'b0;
      ack_tgl   <= ~ack_tgl;
      sum_out   <= sum_c;
      carry_out <= cout_c;
    end
  end
endmodule

// File: rtl/rda_checker.sv
module rda_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         all_known,
  input logic         ack_tgl,
  input logic [W-1:0] sum_out,
  input logic         carry_out,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic         c_q
);
  // R2: an operation only starts when idle, and then runs with carries unsettled
  a_r2_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !all_known);
  // R6: completion ends the operation and flips the acknowledge
  a_r6_done_flips_ack: assert property (@(posedge clk) disable iff (rst)
    busy && all_known |=> !busy && (ack_tgl != $past(ack_tgl)));
  // R6: no acknowledge without a running operation
  a_r6_ack_needs_busy: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_tgl) |-> $past(busy));
  // R6: results hold between acknowledges
  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    $stable(ack_tgl) |-> $stable(sum_out) && $stable(carry_out));
  // R3 / R4: delivered result equals a plain sum of the captured operands
  a_r3_sum_ok: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_tgl) |->
      ({carry_out, sum_out} == ({1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, c_q})));
endmodule

bind ripple_done_adder rda_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .all_known(all_known),
  .ack_tgl(ack_tgl), .sum_out(sum_out), .carry_out(carry_out),
  .a_q(a_q), .b_q(b_q), .c_q(c_q)
);

// File: tb/ripple_done_adder_bench.sv
module ripple_done_adder_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_tgl = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] sum_out;
  logic         carry_out;
  logic         ack_tgl;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ripple_done_adder #(.W(W)) u_ripple_done_adder (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sub_mode(sub_mode), .sum_out(sum_out),
    .carry_out(carry_out), .ack_tgl(ack_tgl)
  );

  task automatic chk(input bit ok, input string tag, input logic [W+1:0] act,
                     input logic [W+1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: effective operand, sum and latency from the requirements
  function automatic logic [W-1:0] eff_b(input logic [W-1:0] b, input logic s);
    return s ? ~b : b;
  endfunction

  function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c, input logic s);
    logic [W:0] r;
    r = {1'b0, a} + {1'b0, eff_b(b, s)} + {{W{1'b0}}, (s | c)};
    return r;
  endfunction

  function automatic int ref_lat(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic s);
    logic [W-1:0] p;
    int run, best;
    p = a ^ eff_b(b, s);
    run = 0;
    best = 0;
    for (int i = 0; i < W; i++) begin
      run = p[i] ? run + 1 : 0;
      if (run > best) best = run;
    end
    return best + 2;
  endfunction

  // Called at a negedge: present operands and flip the request
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input logic s);
    op_a = a; op_b = b; carry_in = c; sub_mode = s;
    req_tgl = ~req_tgl;
  endtask

  // Observes negedges k = first..lat+1 after the sampling edge; ack expected at lat+1
  task automatic follow(input int first, input int lat, input logic ack0,
                        input logic [W:0] prev_res, input logic [W:0] exp_res,
                        input string tag);
    for (int k = first; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k <= lat) begin
        chk(ack_tgl == ack0, {tag, " R5 ack early"}, ack_tgl, ack0);
        chk({carry_out, sum_out} == prev_res, {tag, " R6 result held"},
            {carry_out, sum_out}, prev_res);
      end else begin
        chk(ack_tgl == ~ack0, {tag, " R5 ack on time"}, ack_tgl, ~ack0);
        chk({carry_out, sum_out} == exp_res, {tag, " R3/R4 result"},
            {carry_out, sum_out}, exp_res);
      end
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input logic s, input string tag);
    logic ack0;
    logic [W:0] prev;
    ack0 = ack_tgl;
    prev = {carry_out, sum_out};
    issue(a, b, c, s);
    follow(1, ref_lat(a, b, s), ack0, prev, ref_sum(a, b, c, s), tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic ack0;
    logic [W:0] prev, r1, r2;
    int l1, l2;

    repeat (3) @(negedge clk);
    // R1
    chk({ack_tgl, carry_out, sum_out} == '0, "R1 during reset",
        {ack_tgl, carry_out, sum_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk({ack_tgl, carry_out, sum_out} == '0, "R1 after reset",
        {ack_tgl, carry_out, sum_out}, '0);

    // R2 R3 R5: no propagate bits
    run_op(16'h0000, 16'h0000, 1'b0, 1'b0, "R2 zero add");
    chk(ref_lat(16'h0000, 16'h0000, 1'b0) == 2, "R5 minimum latency", 0, 2);
    run_op(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R3 long run");
    run_op(16'h1234, 16'h0F0F, 1'b1, 1'b0, "R3 carry-in");
    // R9: every bit propagates
    run_op(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R9 full chain");
    chk(ref_lat(16'hFFFF, 16'h0000, 1'b0) == W + 2, "R9 latency", 0, W + 2);
    // R4: subtraction, carry_in ignored
    run_op(16'h0005, 16'h0003, 1'b0, 1'b1, "R4 a>b");
    run_op(16'h0003, 16'h0005, 1'b1, 1'b1, "R4 a<b");
    run_op(16'h8000, 16'h8000, 1'b0, 1'b1, "R4 a==b");

    // R7 / R8: new request and new operands one cycle into a running operation
    ack0 = ack_tgl;
    prev = {carry_out, sum_out};
    r1 = ref_sum(16'h00FF, 16'h0001, 1'b0, 1'b0);
    l1 = ref_lat(16'h00FF, 16'h0001, 1'b0);
    r2 = ref_sum(16'hAAAA, 16'h1111, 1'b0, 1'b1);
    l2 = ref_lat(16'hAAAA, 16'h1111, 1'b1);
    issue(16'h00FF, 16'h0001, 1'b0, 1'b0);
    @(negedge clk);
    chk(ack_tgl == ack0, "R7 ack early", ack_tgl, ack0);
    issue(16'hAAAA, 16'h1111, 1'b0, 1'b1);
    follow(2, l1, ack0, prev, r1, "R7 first op");
    follow(1, l2, ~ack0, r1, r2, "R8 queued op");

    // Mixed pseudo-random operations
    lfsr = 16'hACE1;
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] a, b;
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_op(a, b, lfsr[0], lfsr[1], "R3/R4/R5 mixed");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule